// File: doc/BRIEF.md
# Multiprocessor-Capable Serial Port

A serial port for a host CPU that runs in one of four modes picked by a 2-bit mode input. Mode 0 is a synchronous 8-bit shifter that drives its own shift clock. Mode 1 is an asynchronous 8-bit port. Modes 2 and 3 are asynchronous ports that carry a ninth data bit. The host sets static control inputs: mode, receive enable, address filter and the ninth transmit bit. It starts a transmission with a one-cycle strobe. It reads back two sticky interrupt flags, the received byte and the received ninth bit. Each flag has a clear strobe.

Bit timing comes from an external single-cycle tick at 16 times the bit rate. One bit lasts 16 ticks in every mode. The address filter supports multidrop buses. In the 9-bit modes, the receiver stays silent for frames whose ninth bit is 0. In mode 1, the filter drops frames that have a broken stop bit.

Top module: `serport`

## Requirements
- R1: While reset is asserted and after it is released, txd and sclk are 1, and ti, ri, ninth_rx and rx_data are 0.
- R2: In modes 1 (mode=1), 2 and 3, a tx_start strobe while idle sends a frame on txd. The frame is a 0 start bit, then tx_data LSB first, then ninth_tx (modes 2 and 3 only), then a 1 stop bit. Each bit lasts 16 ticks. txd idles at 1, and a tx_start strobe during a frame is ignored.
- R3: ti rises at the tick that begins the stop bit in modes 1 to 3, and at the tick that ends the 8th bit in mode 0.
- R4: The receiver samples each bit near its middle. A start bit that is high again at its midpoint returns the receiver to idle, and no flag is raised.
- R5: With the filter off, the receiver raises ri at the 9th tick of the stop bit, counted from the tick before the start edge. At the same moment it loads rx_data with the byte received LSB first. ninth_rx is loaded with the ninth bit in modes 2 and 3, and with the stop bit in mode 1.
- R6: In mode 1 with filt_en=1, a frame whose stop bit is 0 raises no ri and leaves rx_data and ninth_rx unchanged. A frame with a stop bit of 1 is accepted.
- R7: In modes 2 and 3 with filt_en=1, a frame whose ninth bit is 0 raises no ri. A frame whose ninth bit is 1 is accepted.
- R8: While rx_en=0 no frame is received, and ri does not rise.
- R9: A frame that completes while ri is still 1 is discarded, and rx_data keeps the earlier byte.
- R10: ti and ri stay at 1 until their clear strobe (ti_clr, ri_clr). A clear strobe drops the flag one clock later.
- R11: In mode 0, tx_start shifts tx_data out LSB first on txd, 16 ticks per bit. sclk is 0 for the first 8 ticks of each bit and 1 for the last 8, and txd and sclk return to 1 after the 8th bit.
- R12: In mode 0 with rx_en=1 and ri=0, the port clocks in 8 bits from rxd, sampled when sclk rises, LSB first. It raises ri at the end of the 8th bit and starts no new transfer while ri is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16x bit rate |
| mode | input | 2 | 0 sync shift, 1 async 8-bit, 2/3 async 9-bit |
| filt_en | input | 1 | Address/stop filter for the receive flag |
| rx_en | input | 1 | Receive enable |
| ninth_tx | input | 1 | Ninth bit sent in modes 2 and 3 |
| tx_start | input | 1 | Start strobe for a transmission |
| tx_data | input | DW | Byte to transmit |
| ti_clr | input | 1 | Clears ti |
| ri_clr | input | 1 | Clears ri |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| sclk | output | 1 | Shift clock in mode 0, 1 otherwise |
| ti | output | 1 | Transmit flag |
| ri | output | 1 | Receive flag |
| ninth_rx | output | 1 | Received ninth bit or stop bit |
| rx_data | output | DW | Last accepted byte |

## Verification
On the transmit side, txd, sclk and ti move one clock after the tick that ends a bit. The bench keeps its own tick count from the accepted tx_start and compares the expected line levels and flag on every falling edge. On the receive side, the two-flop input synchroniser delays the start edge by one tick. ri is therefore due at the 9th tick of the stop bit. The bench checks for 0 one tick before that point and checks the expected value one tick after it. In mode 0, ri is checked as 0 at the 8th sclk rise and as 1 exactly 8 ticks later.

// File: rtl/serport.sv
module serport #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic [1:0]    mode,
  input  logic          filt_en,
  input  logic          rx_en,
  input  logic          ninth_tx,
  input  logic          tx_start,
  input  logic [DW-1:0] tx_data,
  input  logic          ti_clr,
  input  logic          ri_clr,
  input  logic          rxd,
  output logic          txd,
  output logic          sclk,
  output logic          ti,
  output logic          ri,
  output logic          ninth_rx,
  output logic [DW-1:0] rx_data
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] BEND = CW'(OSR - 1);
  localparam logic [3:0] M0_LAST = 4'(DW - 1);
  localparam logic [3:0] D_LAST  = 4'(DW);

  logic [1:0] rs;
  logic rx_s, m0, nine;
  logic [3:0] stop_idx;
  assign rx_s = rs[1];
  assign m0 = (mode == 2'd0);
  assign nine = mode[1];
  assign stop_idx = nine ? 4'(DW + 2) : 4'(DW + 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs <= 2'b11;
    else        rs <= {rs[0], rxd};

  // shared shifter: async transmit, mode 0 transmit and mode 0 receive
  logic          tbusy, trx;
  logic [CW-1:0] tcnt;
  logic [3:0]    tidx;
  logic [DW+1:0] tsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbusy <= 1'b0; trx <= 1'b0; tcnt <= '0; tidx <= '0; tsh <= '0;
      txd <= 1'b1; sclk <= 1'b1;
    end else if (!tbusy) begin
      if (tx_start) begin
        tbusy <= 1'b1; trx <= 1'b0; tcnt <= '0; tidx <= '0;
        if (m0) begin
          txd <= tx_data[0]; sclk <= 1'b0;
          tsh <= {3'b111, tx_data[DW-1:1]};
        end else begin
          txd <= 1'b0;
          tsh <= {1'b1, nine ? ninth_tx : 1'b1, tx_data};
        end
      end else if (m0 && rx_en && !ri) begin
        tbusy <= 1'b1; trx <= 1'b1; tcnt <= '0; tidx <= '0;
        sclk <= 1'b0; tsh <= '0;
      end
    end else if (tick16) begin
      tcnt <= tcnt + 1'b1;
      if (m0) begin
        if (tcnt == MID) begin
          sclk <= 1'b1;
          if (trx) tsh[DW-1:0] <= {rx_s, tsh[DW-1:1]};
        end
        if (tcnt == BEND) begin
          if (tidx == M0_LAST) begin
            tbusy <= 1'b0; txd <= 1'b1;
          end else begin
            tidx <= tidx + 4'd1; sclk <= 1'b0;
            if (!trx) begin
              txd <= tsh[0]; tsh <= {1'b1, tsh[DW+1:1]};
            end
          end
        end
      end else if (tcnt == BEND) begin
        if (tidx == stop_idx) tbusy <= 1'b0;
        else begin
          tidx <= tidx + 4'd1; txd <= tsh[0];
          tsh <= {1'b1, tsh[DW+1:1]};
        end
      end
    end
  end

  logic ti_set, m0_done;
  assign ti_set = tbusy && !trx && tick16 && tcnt == BEND &&
                  (m0 ? tidx == M0_LAST : tidx == stop_idx - 4'd1);
  assign m0_done = tbusy && trx && tick16 && tcnt == BEND &&
                   tidx == M0_LAST && m0 && rx_en && !ri;

  // asynchronous receiver
  logic          ract, r9;
  logic [CW-1:0] rcnt;
  logic [3:0]    ridx;
  logic [DW-1:0] rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ract <= 1'b0; r9 <= 1'b0; rcnt <= '0; ridx <= '0; rsh <= '0;
    end else if (!rx_en || m0) begin
      ract <= 1'b0;
    end else if (tick16) begin
      if (!ract) begin
        if (!rx_s) begin
          ract <= 1'b1; rcnt <= '0; ridx <= '0;
        end
      end else begin
        rcnt <= rcnt + 1'b1;
        if (rcnt == MID) begin
          ridx <= ridx + 4'd1;
          if (ridx == 4'd0) begin
            if (rx_s) ract <= 1'b0;
          end else if (ridx == stop_idx) ract <= 1'b0;
          else if (ridx <= D_LAST) rsh <= {rx_s, rsh[DW-1:1]};
          else r9 <= rx_s;
        end
      end
    end
  end

  logic stop_ev, ninth_val, accept;
  assign stop_ev = ract && tick16 && rcnt == MID && ridx == stop_idx && rx_en && !m0;
  assign ninth_val = nine ? r9 : rx_s;
  assign accept = stop_ev && !ri && (!filt_en || ninth_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ti <= 1'b0; ri <= 1'b0; ninth_rx <= 1'b0; rx_data <= '0;
    end else begin
      if (ti_set)      ti <= 1'b1;
      else if (ti_clr) ti <= 1'b0;
      if (m0_done) begin
        ri <= 1'b1; rx_data <= tsh[DW-1:0];
      end else if (accept) begin
        ri <= 1'b1; rx_data <= rsh; ninth_rx <= ninth_val;
      end else if (ri_clr) ri <= 1'b0;
    end
  end
endmodule

module serport_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          ti_clr,
  input logic          ri_clr,
  input logic          ti,
  input logic          ri,
  input logic          txd,
  input logic          sclk,
  input logic [DW-1:0] rx_data
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (txd && sclk && !ti && !ri));
  a_r8_no_rx_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(ri));
  a_r9_keep_data: assert property (@(posedge clk) disable iff (!rst_n)
    ri && !ri_clr |=> $stable(rx_data));
  a_r10_ti_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ti && !ti_clr |=> ti);
  a_r10_ri_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ri && !ri_clr |=> ri);
endmodule

bind serport serport_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_serport.sv
`timescale 1ns/1ps
module sim_serport;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tick16 = 1'b0, filt_en = 1'b0, rx_en = 1'b0, ninth_tx = 1'b0;
  logic tx_start = 1'b0, ti_clr = 1'b0, ri_clr = 1'b0, rxd = 1'b1;
  logic [1:0] mode = 2'd1;
  logic [7:0] tx_data = 8'h00;
  logic txd, sclk, ti, ri, ninth_rx;
  logic [7:0] rx_data;

  serport u0 (.clk(clk), .rst_n(rst_n), .tick16(tick16), .mode(mode), .filt_en(filt_en),
              .rx_en(rx_en), .ninth_tx(ninth_tx), .tx_start(tx_start), .tx_data(tx_data),
              .ti_clr(ti_clr), .ri_clr(ri_clr), .rxd(rxd), .txd(txd), .sclk(sclk),
              .ti(ti), .ri(ri), .ninth_rx(ninth_rx), .rx_data(rx_data));

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tick16 <= (cyc % 4 == 0);
  end

  // behavioural transmit reference
  bit mact = 0, mm0 = 0, exp_ti = 0, cmp_line = 1;
  int mn = 0, mlen = 0, tiT = 0;
  bit mbits[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mact = 0; exp_ti = 0;
    end else begin
      if (ti_clr) exp_ti = 0;
      if (mact) begin
        if (tick16) begin
          mn++;
          if (mn == tiT) exp_ti = 1;
          if (mn == 16 * mlen) mact = 0;
        end
      end else if (tx_start) begin
        mbits.delete();
        mm0 = (mode == 2'd0);
        if (!mm0) mbits.push_back(1'b0);
        for (int i = 0; i < 8; i++) mbits.push_back(tx_data[i]);
        if (mode[1]) mbits.push_back(ninth_tx);
        if (!mm0) mbits.push_back(1'b1);
        mlen = mbits.size();
        tiT = mm0 ? 128 : 16 * (mlen - 1);
        mn = 0; mact = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmp_line) begin
        bit et, es;
        et = 1; es = 1;
        if (mact) begin
          et = mbits[mn / 16];
          es = mm0 ? ((mn % 16) >= 8) : 1'b1;
        end
        chk(txd == et, mm0 ? "R11 txd level" : "R2 txd level", txd, et);
        chk(sclk == es, mm0 ? "R11 sclk level" : "R2 sclk level", sclk, es);
      end
      chk(ti == exp_ti, "R3 ti timing", ti, exp_ti);
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick16) @(posedge clk);
    end
  endtask

  task automatic clr_ti();
    @(negedge clk) ti_clr = 1;
    @(negedge clk) ti_clr = 0;
  endtask

  task automatic clr_ri();
    @(negedge clk) ri_clr = 1;
    @(negedge clk) ri_clr = 0;
    chk(ri == 0, "R10 ri cleared by strobe", ri, 0);
  endtask

  task automatic send_tx(input logic [1:0] md, input logic [7:0] d, input bit b9, input bit poke);
    @(negedge clk);
    mode = md; ninth_tx = b9; tx_data = d; tx_start = 1;
    @(negedge clk) tx_start = 0;
    if (poke) begin
      repeat (100) @(negedge clk);
      tx_data = ~d; tx_start = 1;
      @(negedge clk) tx_start = 0; tx_data = d;
    end
    while (mact) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(ti == 1, "R10 ti held after frame", ti, 1);
    clr_ti();
    @(negedge clk);
    chk(ti == 0, "R10 ti cleared by strobe", ti, 0);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit nine, input bit b9, input bit stopb,
                         input bit exp_ri, input string req);
    int s;
    bit ri0;
    s = nine ? 10 : 9;
    ri0 = ri;
    wait_ticks(1);
    @(negedge clk) rxd = 0;
    for (int b = 1; b <= s; b++) begin
      wait_ticks(16);
      @(negedge clk);
      if (b <= 8) rxd = d[b-1];
      else if (b == s) rxd = stopb;
      else rxd = b9;
    end
    wait_ticks(8);
    @(negedge clk);
    if (!ri0) chk(ri == 0, "R5 ri not before stop midpoint", ri, 0);
    wait_ticks(2);
    @(negedge clk);
    chk(ri == exp_ri, req, ri, exp_ri);
    wait_ticks(6);
    @(negedge clk) rxd = 1;
    wait_ticks(24);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1 && sclk == 1, "R1 reset line idle", {txd, sclk}, 3);
    chk(ti == 0 && ri == 0 && ninth_rx == 0, "R1 reset flags", {ti, ri, ninth_rx}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rx_data == 0, "R1 reset rx_data", rx_data, 0);

    // transmit
    send_tx(2'd1, 8'hA5, 1'b0, 1'b1);   // R2 with ignored restart
    send_tx(2'd2, 8'h3C, 1'b1, 1'b0);   // R2 ninth bit 1
    send_tx(2'd3, 8'h81, 1'b0, 1'b0);   // R2 ninth bit 0
    send_tx(2'd0, 8'h6B, 1'b0, 1'b0);   // R11
    @(negedge clk) mode = 2'd1;

    // receive, mode 1
    @(negedge clk) rx_en = 1;
    send_rx(8'h5A, 0, 0, 1, 1, "R5 ri at stop midpoint m1");
    chk(rx_data == 8'h5A, "R5 rx_data m1", rx_data, 8'h5A);
    chk(ninth_rx == 1, "R5 stop bit into ninth_rx", ninth_rx, 1);
    clr_ri();
    send_rx(8'hC7, 0, 0, 0, 1, "R5 bad stop accepted with filter off");
    chk(ninth_rx == 0, "R5 stop 0 into ninth_rx", ninth_rx, 0);
    clr_ri();
    @(negedge clk) filt_en = 1;
    send_rx(8'h11, 0, 0, 0, 0, "R6 bad stop filtered");
    chk(rx_data == 8'hC7, "R6 rx_data unchanged", rx_data, 8'hC7);
    chk(ninth_rx == 0, "R6 ninth_rx unchanged", ninth_rx, 0);
    send_rx(8'h96, 0, 0, 1, 1, "R6 good stop accepted");
    chk(rx_data == 8'h96, "R6 rx_data loaded", rx_data, 8'h96);
    clr_ri();

    // receive, 9-bit modes
    @(negedge clk) filt_en = 0; mode = 2'd3;
    send_rx(8'h2E, 1, 1, 1, 1, "R5 ri at stop midpoint m3");
    chk(rx_data == 8'h2E && ninth_rx == 1, "R5 data and ninth m3", {ninth_rx, rx_data}, 9'h12E);
    clr_ri();
    @(negedge clk) filt_en = 1; mode = 2'd2;
    send_rx(8'h44, 1, 0, 1, 0, "R7 ninth 0 filtered");
    chk(rx_data == 8'h2E, "R7 rx_data unchanged", rx_data, 8'h2E);
    send_rx(8'hB3, 1, 1, 1, 1, "R7 ninth 1 accepted");
    chk(rx_data == 8'hB3, "R7 rx_data loaded", rx_data, 8'hB3);

    // R9: ri still set
    send_rx(8'h0F, 1, 1, 1, 1, "R9 ri stays set");
    chk(rx_data == 8'hB3, "R9 old data kept", rx_data, 8'hB3);
    clr_ri();

    // R8: receiver disabled
    @(negedge clk) rx_en = 0; filt_en = 0; mode = 2'd1;
    send_rx(8'h77, 0, 0, 1, 0, "R8 no ri while disabled");
    chk(rx_data == 8'hB3, "R8 rx_data unchanged", rx_data, 8'hB3);

    // R4: false start
    @(negedge clk) rx_en = 1;
    wait_ticks(1);
    @(negedge clk) rxd = 0;
    wait_ticks(4);
    @(negedge clk) rxd = 1;
    wait_ticks(200);
    @(negedge clk);
    chk(ri == 0, "R4 false start ignored", ri, 0);
    send_rx(8'hE2, 0, 0, 1, 1, "R4 receiver recovers");
    chk(rx_data == 8'hE2, "R4 data after false start", rx_data, 8'hE2);
    clr_ri();

    // R12: mode 0 receive
    @(negedge clk) rx_en = 0;
    @(negedge clk) cmp_line = 0; mode = 2'd0;
    @(negedge clk) rx_en = 1;
    begin
      logic [7:0] v;
      v = 8'hC3;
      while (sclk) @(negedge clk);
      rxd = v[0];
      for (int i = 1; i < 8; i++) begin
        while (!sclk) @(negedge clk);
        while (sclk) @(negedge clk);
        rxd = v[i];
      end
      while (!sclk) @(negedge clk);
      chk(ri == 0, "R12 ri not before end of 8th bit", ri, 0);
      wait_ticks(8);
      @(negedge clk);
      chk(ri == 1, "R12 ri at end of 8th bit", ri, 1);
      chk(rx_data == v, "R12 mode 0 data", rx_data, v);
    end
    begin
      bit held;
      held = 1;
      repeat (200) begin
        @(negedge clk);
        if (!sclk) held = 0;
      end
      chk(held, "R12 no transfer while ri set", held, 1);
    end
    @(negedge clk) rx_en = 0;
    clr_ri();
    @(negedge clk) rxd = 1; mode = 2'd1;
    repeat (4) @(negedge clk);
    cmp_line = 1;
    repeat (10) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule